// File: doc/BRIEF.md
# Sign-Indexed Mesh Routing Table

This block is the routing-decision table of a mesh router. The table is written through a configuration port. Each node keeps its own coordinates in a node-ID register. For every header that arrives, the block compares the destination coordinate in each dimension with the node's own coordinate. The result per dimension is one of three relations: smaller, equal or larger. These relations together select one table entry. For a 2-D mesh there are 9 entries, whatever the size of the mesh.

Each entry names up to two permitted output ports and carries a 2-bit mask that marks which of the two slots hold a valid port. Software programs the entries, and the programmed contents decide the routing algorithm. Examples:
- Fully adaptive minimal routing offers both productive ports when the destination lies in a quadrant.
- A north-last restriction removes the north choice whenever a second productive direction exists.

Lookups flow as a valid/ready stream with one register stage. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The registered result appears with `rsp_valid` after that edge. The result stays frozen while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. So back-pressure on the response side passes straight back to the request side, and the stream loses no bubble when the consumer is always ready.

Top module: `mesh_route_table`

## Requirements
- R1: For each dimension the block forms a sign code from an unsigned compare of destination against own coordinate: 2'b01 when the destination is larger, 2'b10 when smaller, 2'b00 when equal. This holds over the full range 0..15 with no wrap. Dimension 0 (x) is `req_dest[3:0]` and dimension 1 (y) is `req_dest[7:4]`; the node ID uses the same packing.
- R2: The entry index is 3*code(x) + code(y), giving 9 entries (0..8). The response carries the mask and ports of exactly that entry.
- R3: A response presents an entry's stored 2-bit mask, port slot 0 and port slot 1 unchanged. Mask bit 0 marks slot 0 valid and bit 1 marks slot 1 valid.
- R4: After reset the node ID is 0, every entry has mask 2'b00 with both ports 0, `rsp_valid` is low and `req_ready` is high.
- R5: A request accepted at a clock edge produces `rsp_valid` high after that same edge. `rsp_valid` never rises without an acceptance at that edge.
- R6: While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` is low.
- R7: An entry write takes effect for requests accepted at later edges. A request accepted at the same edge as the write returns the old contents.
- R8: Writing the node-ID register changes the signs computed for all later requests.
- R9: With port codes local=0, +x=1, -x=2, +y=3, -y=4 and a fully adaptive minimal program, the results are as follows. A quadrant destination returns mask 2'b11 with the x port in slot 0 and the y port in slot 1. An on-axis destination returns mask 2'b01 with its single port. The node's own address returns mask 2'b01 with port 0.
- R10: With a north-last program (north is +y), quadrant destinations that need +y return only the x port, with mask 2'b01.
- R11: Entry writes to addresses 9..15 are ignored and leave every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_node_we | input | 1 | Write enable for the node-ID register |
| cfg_node_id | input | 8 | New node coordinates, x in [3:0], y in [7:4] |
| cfg_ent_we | input | 1 | Write enable for one table entry |
| cfg_ent_addr | input | 4 | Entry index to write |
| cfg_ent_mask | input | 2 | Slot valid mask to store |
| cfg_ent_port0 | input | 3 | Port stored in slot 0 |
| cfg_ent_port1 | input | 3 | Port stored in slot 1 |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_dest | input | 8 | Destination coordinates, x in [3:0], y in [7:4] |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_mask | output | 2 | Valid mask of the two port slots |
| rsp_port0 | output | 3 | Port in slot 0 |
| rsp_port1 | output | 3 | Port in slot 1 |

## Verification
The assertions check the stream rules on every cycle:
- acceptance always yields a response one edge later;
- no response appears without an acceptance;
- a stalled response is frozen and blocks new requests;
- the internal sign codes never take the unused value;
- the computed index never exceeds 8.

Whether the right entry is chosen for a given coordinate pair can only be shown by the bench. It sweeps every destination against several node IDs, including the corners of the coordinate range. The bench also covers the reset contents, ignored out-of-range writes, the ordering of a write against a lookup in the same cycle, and the results of fully adaptive and north-last programs.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

  typedef enum logic [1:0] {
    SGN_ZERO = 2'b00,
    SGN_POS  = 2'b01,
    SGN_NEG  = 2'b10
  } sgn_e;

  function automatic int pow3(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction

endpackage

// File: rtl/rt_sign_cmp.sv
module rt_sign_cmp #(
  parameter int CW = 4
) (
  input  logic [CW-1:0]      dst,
  input  logic [CW-1:0]      own,
  output mesh_rt_pkg::sgn_e  sgn
);
  import mesh_rt_pkg::*;

  // unsigned compare: no subtraction, so no overflow over the full range
  always_comb begin
    if (dst > own)      sgn = SGN_POS;
    else if (dst < own) sgn = SGN_NEG;
    else                sgn = SGN_ZERO;
  end
endmodule

// File: rtl/rt_index_build.sv
module rt_index_build #(
  parameter int NDIM = 2,
  parameter int IW   = 4
) (
  input  logic [2*NDIM-1:0] sgn_vec,
  output logic [IW-1:0]     idx
);
  // base-3 number, dimension 0 most significant
  always_comb begin
    logic [IW-1:0] acc;
    acc = '0;
    for (int d = 0; d < NDIM; d++) begin
      acc = IW'(acc * IW'(3)) + IW'(sgn_vec[2*d +: 2]);
    end
    idx = acc;
  end
endmodule

// File: rtl/rt_entry_file.sv
module rt_entry_file #(
  parameter int NENT = 9,
  parameter int IW   = 4,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [1:0]    wr_mask,
  input  logic [PW-1:0] wr_p0,
  input  logic [PW-1:0] wr_p1,
  input  logic [IW-1:0] rd_idx,
  output logic [1:0]    rd_mask,
  output logic [PW-1:0] rd_p0,
  output logic [PW-1:0] rd_p1
);
  logic [1:0]    mask_q [NENT];
  logic [PW-1:0] p0_q   [NENT];
  logic [PW-1:0] p1_q   [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        mask_q[e] <= 2'b00;
        p0_q[e]   <= '0;
        p1_q[e]   <= '0;
      end
    end else if (wr_en && (wr_addr < IW'(NENT))) begin
      mask_q[wr_addr] <= wr_mask;
      p0_q[wr_addr]   <= wr_p0;
      p1_q[wr_addr]   <= wr_p1;
    end
  end

  always_comb begin
    rd_mask = 2'b00;
    rd_p0   = '0;
    rd_p1   = '0;
    if (rd_idx < IW'(NENT)) begin
      rd_mask = mask_q[rd_idx];
      rd_p0   = p0_q[rd_idx];
      rd_p1   = p1_q[rd_idx];
    end
  end
endmodule

// File: rtl/mesh_route_table.sv
module mesh_route_table #(
  parameter int NDIM = 2,
  parameter int CW   = 4,
  parameter int PW   = 3,
  localparam int NENT = mesh_rt_pkg::pow3(NDIM),
  localparam int IW   = $clog2(NENT),
  localparam int DW   = NDIM * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_node_we,
  input  logic [DW-1:0] cfg_node_id,
  input  logic          cfg_ent_we,
  input  logic [IW-1:0] cfg_ent_addr,
  input  logic [1:0]    cfg_ent_mask,
  input  logic [PW-1:0] cfg_ent_port0,
  input  logic [PW-1:0] cfg_ent_port1,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_dest,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_mask,
  output logic [PW-1:0] rsp_port0,
  output logic [PW-1:0] rsp_port1
);
  logic [DW-1:0]     node_q;
  logic [2*NDIM-1:0] sgn_vec;
  logic [IW-1:0]     tbl_idx;
  logic [1:0]        rd_mask;
  logic [PW-1:0]     rd_p0;
  logic [PW-1:0]     rd_p1;
  logic              rsp_valid_q;
  logic [1:0]        mask_q;
  logic [PW-1:0]     p0_q;
  logic [PW-1:0]     p1_q;
  logic              accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           node_q <= '0;
    else if (cfg_node_we) node_q <= cfg_node_id;
  end

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    mesh_rt_pkg::sgn_e s;
    rt_sign_cmp #(.CW(CW)) u_cmp (
      .dst (req_dest[d*CW +: CW]),
      .own (node_q[d*CW +: CW]),
      .sgn (s)
    );
    assign sgn_vec[2*d +: 2] = s;
  end

  rt_index_build #(.NDIM(NDIM), .IW(IW)) u_idx (
    .sgn_vec (sgn_vec),
    .idx     (tbl_idx)
  );

  rt_entry_file #(.NENT(NENT), .IW(IW), .PW(PW)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_ent_we),
    .wr_addr (cfg_ent_addr),
    .wr_mask (cfg_ent_mask),
    .wr_p0   (cfg_ent_port0),
    .wr_p1   (cfg_ent_port1),
    .rd_idx  (tbl_idx),
    .rd_mask (rd_mask),
    .rd_p0   (rd_p0),
    .rd_p1   (rd_p1)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      mask_q      <= 2'b00;
      p0_q        <= '0;
      p1_q        <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      mask_q      <= rd_mask;
      p0_q        <= rd_p0;
      p1_q        <= rd_p1;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_mask  = mask_q;
  assign rsp_port0 = p0_q;
  assign rsp_port1 = p1_q;
endmodule

// File: rtl/mesh_rt_chk.sv
module mesh_rt_chk #(
  parameter int NDIM = 2,
  parameter int PW   = 3,
  parameter int NENT = 9,
  parameter int IW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_mask,
  input logic [PW-1:0]     rsp_port0,
  input logic [PW-1:0]     rsp_port1,
  input logic [2*NDIM-1:0] sgn_vec,
  input logic [IW-1:0]     tbl_idx
);
  for (genvar d = 0; d < NDIM; d++) begin : g_sgn
    AST_SIGN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sgn_vec[2*d +: 2] != 2'b11); // R1
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_idx < IW'(NENT)); // R2

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready)); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask)
      && $stable(rsp_port0) && $stable(rsp_port1))); // R6

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R6
endmodule

bind mesh_route_table mesh_rt_chk #(
  .NDIM(NDIM), .PW(PW), .NENT(NENT), .IW(IW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_mask  (rsp_mask),
  .rsp_port0 (rsp_port0),
  .rsp_port1 (rsp_port1),
  .sgn_vec   (sgn_vec),
  .tbl_idx   (tbl_idx)
);

// File: tb/mesh_route_table_tb.sv
module mesh_route_table_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_node_we = 1'b0;
  logic [7:0] cfg_node_id = '0;
  logic       cfg_ent_we = 1'b0;
  logic [3:0] cfg_ent_addr = '0;
  logic [1:0] cfg_ent_mask = '0;
  logic [2:0] cfg_ent_port0 = '0;
  logic [2:0] cfg_ent_port1 = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_dest = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_mask;
  logic [2:0] rsp_port0;
  logic [2:0] rsp_port1;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  mesh_route_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_node_we(cfg_node_we), .cfg_node_id(cfg_node_id),
    .cfg_ent_we(cfg_ent_we), .cfg_ent_addr(cfg_ent_addr),
    .cfg_ent_mask(cfg_ent_mask), .cfg_ent_port0(cfg_ent_port0),
    .cfg_ent_port1(cfg_ent_port1),
    .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_mask(rsp_mask), .rsp_port0(rsp_port0), .rsp_port1(rsp_port1)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int code(input int d, input int o);
    if (d > o) return 1;
    if (d < o) return 2;
    return 0;
  endfunction

  // pattern entry contents, distinct per index
  function automatic logic [7:0] pat(input int e);
    logic [1:0] m;
    logic [2:0] a;
    logic [2:0] b;
    m = 2'(e % 4);
    a = 3'(e % 8);
    b = 3'(e / 2);
    return {m, a, b};
  endfunction

  task automatic wr_node(input int x, input int y);
    @(negedge clk);
    cfg_node_we = 1'b1; cfg_node_id = {4'(y), 4'(x)};
    @(negedge clk);
    cfg_node_we = 1'b0;
  endtask

  task automatic wr_ent(input int a, input logic [1:0] m, input logic [2:0] p0, input logic [2:0] p1);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_ent_addr = 4'(a);
    cfg_ent_mask = m; cfg_ent_port0 = p0; cfg_ent_port1 = p1;
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  // returns {valid, mask, port0, port1}
  task automatic look(input int x, input int y, output logic [8:0] r);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_dest = {4'(y), 4'(x)};
    @(negedge clk);
    req_valid = 1'b0;
    r = {rsp_valid, rsp_mask, rsp_port0, rsp_port1};
  endtask

  task automatic load_pattern();
    for (int e = 0; e < 9; e++) begin
      logic [7:0] p;
      p = pat(e);
      wr_ent(e, p[7:6], p[5:3], p[2:0]);
    end
  endtask

  task automatic sweep_pattern(input int nx, input int ny, input string req);
    for (int y = 0; y < 16; y++) begin
      for (int x = 0; x < 16; x++) begin
        logic [8:0] r;
        int idx;
        logic [7:0] p;
        idx = 3 * code(x, nx) + code(y, ny);
        p = pat(idx);
        look(x, y, r);
        chk(req, 32'(r), 32'({1'b1, p}));
      end
    end
  endtask

  // adaptive minimal program, ports local 0, +x 1, -x 2, +y 3, -y 4
  function automatic logic [7:0] route(input int cx, input int cy, input bit nlast);
    int px;
    int py;
    px = (cx == 1) ? 1 : (cx == 2) ? 2 : 0;
    py = (cy == 1) ? 3 : (cy == 2) ? 4 : 0;
    if (px != 0 && py != 0) begin
      if (nlast && py == 3) return {2'b01, 3'(px), 3'd0};
      return {2'b11, 3'(px), 3'(py)};
    end
    if (px != 0) return {2'b01, 3'(px), 3'd0};
    if (py != 0) return {2'b01, 3'(py), 3'd0};
    return {2'b01, 3'd0, 3'd0};
  endfunction

  task automatic load_route(input bit nlast);
    for (int cx = 0; cx < 3; cx++)
      for (int cy = 0; cy < 3; cy++) begin
        logic [7:0] p;
        p = route(cx, cy, nlast);
        wr_ent(3 * cx + cy, p[7:6], p[5:3], p[2:0]);
      end
  endtask

  task automatic sweep_route(input int nx, input int ny, input bit nlast, input string req);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        logic [8:0] r;
        logic [7:0] p;
        p = route(code(x, nx), code(y, ny), nlast);
        look(x, y, r);
        chk(req, 32'(r), 32'({1'b1, p}));
      end
  endtask

  initial begin
    logic [8:0] r;
    logic [7:0] p;
    repeat (3) @(negedge clk);
    chk("R4 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R4 req_ready after reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    // R4: all entries invalid, node 0
    for (int y = 0; y < 16; y += 3)
      for (int x = 0; x < 16; x += 3) begin
        look(x, y, r);
        chk("R4 entry invalid at reset", 32'(r), 32'h100);
      end

    // R1 R2 R3 R8: pattern sweeps over node IDs at range corners
    load_pattern();
    sweep_pattern(0, 0, "R1 R2 R3 node(0,0)");
    wr_node(15, 15);
    sweep_pattern(15, 15, "R1 R8 node(15,15)");
    wr_node(7, 9);
    sweep_pattern(7, 9, "R2 R3 node(7,9)");
    wr_node(15, 0);
    sweep_pattern(15, 0, "R8 node(15,0)");

    // R11: out-of-range writes ignored
    for (int a = 9; a < 16; a++) wr_ent(a, 2'b11, 3'd7, 3'd7);
    sweep_pattern(15, 0, "R11 ignored writes");

    // R7: write and lookup accepted at the same edge -> old value, then new
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_ent_addr = 4'd4;
    cfg_ent_mask = 2'b10; cfg_ent_port0 = 3'd6; cfg_ent_port1 = 3'd5;
    rsp_ready = 1'b1; req_valid = 1'b1; req_dest = {4'd1, 4'd0};   // x<15 neg, y>0 pos: 3*2+1 = 7
    wr_node(15, 0);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_ent_addr = 4'd7;
    cfg_ent_mask = 2'b10; cfg_ent_port0 = 3'd6; cfg_ent_port1 = 3'd5;
    req_valid = 1'b1; req_dest = {4'd1, 4'd0};
    @(negedge clk);
    cfg_ent_we = 1'b0; req_valid = 1'b0;
    p = pat(7);
    chk("R7 same-edge write returns old", 32'({rsp_valid, rsp_mask, rsp_port0, rsp_port1}), 32'({1'b1, p}));
    look(0, 1, r);
    chk("R7 later lookup returns new", 32'(r), 32'({1'b1, 2'b10, 3'd6, 3'd5}));

    // R5 R6: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_dest = {4'd0, 4'd15}; // idx 0
    @(negedge clk);
    p = pat(0);
    chk("R5 response one edge after accept", 32'(rsp_valid), 32'd1);
    req_dest = {4'd1, 4'd0}; // idx 7 pending
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 req_ready low while stalled", 32'(req_ready), 32'd0);
      chk("R6 response held", 32'({rsp_valid, rsp_mask, rsp_port0, rsp_port1}), 32'({1'b1, p}));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 pending request taken on drain", 32'({rsp_valid, rsp_mask, rsp_port0, rsp_port1}),
        32'({1'b1, 2'b10, 3'd6, 3'd5}));
    @(negedge clk);
    chk("R5 idle after drain", 32'(rsp_valid), 32'd0);

    // R9: fully adaptive minimal program
    load_route(1'b0);
    wr_node(5, 10);
    sweep_route(5, 10, 1'b0, "R9 adaptive minimal");
    wr_node(0, 15);
    sweep_route(0, 15, 1'b0, "R9 adaptive corner");
    // R10: north-last program
    load_route(1'b1);
    wr_node(5, 10);
    sweep_route(5, 10, 1'b1, "R10 north-last");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule